// File: doc/BRIEF.md
# Out-of-Range Alert with Persistence

This block watches a stream of 16-bit conversion results from the primary measurement channel and raises an alert when results fall outside a programmable window. A result counts as outside the window when it is below the lower limit or above the upper limit. The lower limit is tested first. If the lower limit is set above the upper limit, the upper limit is not used.

A 4-bit persistence code sets how many out-of-range results in a row are needed before the alert is raised. The mapping between code and count is not linear. One code raises the alert on every result. Once raised, the alert flag stays set until a one-cycle clear pulse arrives. The flag is always visible. An enable mask decides whether the flag also drives the active-low request line.

The block sits between the converter's result strobe and the chip's interrupt pad logic. Its limits, code, mask and clear come from a register file outside the block.

Top module: `range_alert`

## Requirements
- R1: When a sample strobe arrives, `smp_data` is out of range if it is strictly below `lim_lo`, or strictly above `lim_hi`. A value equal to either limit is in range.
- R2: When `lim_lo > lim_hi`, the upper comparison is ignored. A sample at or above `lim_lo` then never counts as out of range, however large it is.
- R3: With `pers_code` = 0, every sample strobe sets `irq_flag`, whether the sample is in range or not.
- R4: `pers_code` values 1, 2 and 3 require that many consecutive out-of-range samples. Code values 4 to 15 require 5×(code−3) samples, so code 4 needs 5 and code 15 needs 60. The flag sets on the sample that reaches the count.
- R5: An in-range sample resets the consecutive count to zero. The count stops at the required value and does not wrap. If the code is lowered, the lower value applies from the next out-of-range sample.
- R6: Once set, `irq_flag` stays set through any number of further samples. It clears at the edge that samples `irq_clr`. The clear also resets the consecutive count, so counting starts again from zero.
- R7: If `irq_clr` and a sample that sets the flag arrive in the same clock, the flag ends up set. The count restarts from zero before that sample is applied.
- R8: `irq_flag` updates regardless of `irq_en`. `irq_n` is low exactly when `irq_flag` is 1 and `irq_en` is 1; `irq_en` has combinational effect.
- R9: The flag and the count change only at a clock edge where `smp_vld` is 1 (or, for clearing, where `irq_clr` is 1). The flag becomes visible in the cycle after the strobe. `smp_data` has no effect while `smp_vld` is 0.
- R10: A synchronous active-low reset leaves `irq_flag` at 0, the count at 0 and `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe marking a new conversion result |
| smp_data | input | 16 | Primary channel result |
| lim_lo | input | 16 | Lower window limit |
| lim_hi | input | 16 | Upper window limit |
| pers_code | input | 4 | Persistence code |
| irq_en | input | 1 | Mask: lets the flag drive the request line |
| irq_clr | input | 1 | One-cycle clear of flag and count |
| irq_flag | output | 1 | Sticky alert status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench goes after values exactly on each limit: a design using non-strict compares would alert there. It tests inverted windows with very large samples, where a design that keeps the upper test alive would alert wrongly. It probes counts one short of the target at codes 4 and 15, where a linear decode or an off-by-one would fire early or late. It also checks a clear and a qualifying sample in the same clock, where the wrong priority would drop a real alert, and a clear followed by a single out-of-range sample, where a count the clear left untouched would fire too soon. Randomized windows, codes, masks and clears are compared against a reference model of the requirements, along with strobe gaps that must not advance the count.

// File: rtl/range_alert_pkg.sv
// Shared constants and the persistence decode for the range alert block.
// Assumes a 4-bit code: low codes count literally, higher codes in steps of 5.
package range_alert_pkg;
    localparam int CODE_W     = 4;
    localparam int LIT_MAX    = 3;   // codes up to this value give their own count
    localparam int STEP_SIZE  = 5;   // count increment per code above LIT_MAX
    localparam int MAX_TARGET = ((1 << CODE_W) - 1 - LIT_MAX) * STEP_SIZE;
    localparam int CNT_W      = $clog2(MAX_TARGET + 1);

    // Required consecutive out-of-range count for a persistence code (0 = every sample).
    function automatic int unsigned pers_target(input logic [CODE_W-1:0] code);
        if (int'(code) <= LIT_MAX)
            return int'(code);
        return (int'(code) - LIT_MAX) * STEP_SIZE;
    endfunction
endpackage

// File: rtl/range_alert_window.sv
// Window comparator: flags a sample below the lower limit or above the upper one.
// Assumes unsigned data. An inverted window (lower > upper) disables the upper test.
module range_alert_window #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sample_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    output logic              outside_o
);
    logic below;
    logic above;
    logic hi_usable;

    // Lower test first; the upper test only counts when the window is ordered.
    always_comb begin
        below     = sample_i < lo_i;
        hi_usable = lo_i <= hi_i;
        above     = hi_usable && (sample_i > hi_i);
        outside_o = below || above;
    end
endmodule

// File: rtl/range_alert_persist.sv
// Consecutive out-of-range counter with a decoded target; emits a one-cycle fire.
// Assumes vld_i is a one-cycle strobe. A clear zeroes the count before the sample applies.
module range_alert_persist
    import range_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              outside_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clr_i,
    output logic              fire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] tgt;
    logic [CNT_W-1:0] nxt;

    // Next count and fire decision for the current strobe.
    always_comb begin
        tgt    = CNT_W'(pers_target(code_i));
        base   = clr_i ? '0 : cnt_q;
        nxt    = base;
        fire_o = 1'b0;
        if (vld_i) begin
            if (outside_i)
                nxt = (base >= tgt) ? tgt : base + 1'b1;
            else
                nxt = '0;
            fire_o = (code_i == '0) || (outside_i && (nxt >= tgt));
        end
    end

    // Count register, synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= nxt;
    end

    assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_TARGET));
    assert_inrange_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !outside_i) |=> (cnt_q == '0));
    assert_clr_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !vld_i) |=> (cnt_q == '0));
endmodule

// File: rtl/range_alert_latch.sv
// Sticky alert flag with clear and the masked active-low request line.
// Assumes set_i and clr_i are single-cycle; set has priority over clear.
module range_alert_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_n_o
);
    logic flag_q;

    // Hold the flag until cleared; a new set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    // Mask gates only the pin, never the status.
    always_comb begin
        flag_o  = flag_q;
        irq_n_o = ~(flag_q & en_i);
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_q));
    assert_clr_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_q);
endmodule

// File: rtl/range_alert.sv
// Out-of-range alert: window compare, persistence filter and sticky masked flag.
// Assumes limits and code are stable around strobes; everything resets to zero.
module range_alert
    import range_alert_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] lim_lo,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [CODE_W-1:0] pers_code,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              irq_flag,
    output logic              irq_n
);
    logic outside;
    logic fire;

    range_alert_window #(.DATA_W(DATA_W)) u_window (
        .sample_i (smp_data),
        .lo_i     (lim_lo),
        .hi_i     (lim_hi),
        .outside_o(outside)
    );

    range_alert_persist u_persist (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (smp_vld),
        .outside_i(outside),
        .code_i   (pers_code),
        .clr_i    (irq_clr),
        .fire_o   (fire)
    );

    range_alert_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fire),
        .clr_i  (irq_clr),
        .en_i   (irq_en),
        .flag_o (irq_flag),
        .irq_n_o(irq_n)
    );

    assert_below_fires_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pers_code == CODE_W'(1) && smp_data < lim_lo) |=> irq_flag);
    assert_high_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pers_code == CODE_W'(1) && lim_lo > lim_hi && smp_data >= lim_lo
         && !irq_flag) |=> !irq_flag);
    assert_every_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && pers_code == '0) |=> irq_flag);
    assert_line_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> irq_flag);
    assert_rise_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(smp_vld));
endmodule

// File: tb/sim_range_alert.sv
// Bench for range_alert: directed corners plus seeded random traffic vs a reference model.
module sim_range_alert;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 7341;
    localparam int RAND_CYC   = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [15:0] dat = '0;
    logic [15:0] lo = '0;
    logic [15:0] hi = '0;
    logic [3:0]  code = '0;
    logic        en = 1'b0;
    logic        clr = 1'b0;
    logic        irq_flag;
    logic        irq_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  ref_cnt = 0;
    logic ref_flag = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    range_alert u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(vld), .smp_data(dat),
        .lim_lo(lo), .lim_hi(hi), .pers_code(code), .irq_en(en),
        .irq_clr(clr), .irq_flag(irq_flag), .irq_n(irq_n)
    );

    // Required count per code, from R4.
    function automatic int need_of(input int c);
        return (c <= 3) ? c : (c - 3) * 5;
    endfunction

    // Out-of-range test per R1 and R2.
    function automatic logic is_out(input int d, input int l, input int h);
        return (d < l) || ((l <= h) && (d > h));
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference update after a clock edge (R3-R7).
    task automatic model(input logic v, input logic [15:0] d, input logic c);
        int   b = c ? 0 : ref_cnt;
        int   t = need_of(int'(code));
        logic f = 1'b0;
        if (v) begin
            if (is_out(int'(d), int'(lo), int'(hi)))
                b = (b + 1 > t) ? t : b + 1;
            else
                b = 0;
            f = (code == 4'd0) || (is_out(int'(d), int'(lo), int'(hi)) && b >= t);
        end
        ref_cnt = b;
        if (f) ref_flag = 1'b1;
        else if (c) ref_flag = 1'b0;
    endtask

    // Drive one cycle from a falling edge; returns at the next falling edge.
    task automatic step(input logic v, input logic [15:0] d, input logic c);
        vld = v; dat = d; clr = c;
        @(posedge clk);
        model(v, d, c);
        @(negedge clk);
        vld = 1'b0; clr = 1'b0;
    endtask

    task automatic expect_flag(input string req, input logic f);
        chk(req, "irq_flag", irq_flag, f);
        chk(req, "irq_n", irq_n, !(f && en));
    endtask

    task automatic clear_all();
        step(1'b0, 16'd0, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(SEED));
        repeat (3) @(negedge clk);
        en = 1'b1;
        expect_flag("R10", 1'b0);
        rst_n = 1'b1;

        // R1: limits themselves are in range.
        lo = 16'd100; hi = 16'd200; code = 4'd1;
        step(1'b1, 16'd100, 1'b0); expect_flag("R1", 1'b0);
        step(1'b1, 16'd200, 1'b0); expect_flag("R1", 1'b0);
        step(1'b1, 16'd201, 1'b0); expect_flag("R1", 1'b1);
        clear_all();               expect_flag("R6", 1'b0);
        step(1'b1, 16'd99, 1'b0);  expect_flag("R1", 1'b1);
        step(1'b1, 16'd150, 1'b0); expect_flag("R6", 1'b1);
        step(1'b1, 16'd150, 1'b0); expect_flag("R6", 1'b1);
        clear_all();               expect_flag("R6", 1'b0);

        // R2: inverted window ignores the upper limit.
        lo = 16'd300; hi = 16'd200;
        step(1'b1, 16'd400, 1'b0);   expect_flag("R2", 1'b0);
        step(1'b1, 16'hFFFF, 1'b0);  expect_flag("R2", 1'b0);
        step(1'b1, 16'd299, 1'b0);   expect_flag("R2", 1'b1);
        clear_all();

        // R3: code 0 fires on an in-range sample; R9: no strobe, no change.
        lo = 16'd100; hi = 16'd200; code = 4'd0;
        step(1'b0, 16'd150, 1'b0); expect_flag("R9", 1'b0);
        step(1'b1, 16'd150, 1'b0); expect_flag("R3", 1'b1);
        clear_all();

        // R4: counts for codes 2, 4 and 15.
        code = 4'd2;
        step(1'b1, 16'd5, 1'b0); expect_flag("R4", 1'b0);
        step(1'b1, 16'd5, 1'b0); expect_flag("R4", 1'b1);
        clear_all();
        code = 4'd4;
        for (int i = 0; i < 4; i++) step(1'b1, 16'd5, 1'b0);
        expect_flag("R4", 1'b0);
        step(1'b1, 16'd5, 1'b0); expect_flag("R4", 1'b1);
        clear_all();
        code = 4'd15;
        for (int i = 0; i < 59; i++) step(1'b1, 16'd900, 1'b0);
        expect_flag("R4", 1'b0);
        step(1'b1, 16'd900, 1'b0); expect_flag("R4", 1'b1);
        clear_all();

        // R5: an in-range sample restarts the run.
        code = 4'd3;
        step(1'b1, 16'd5, 1'b0); step(1'b1, 16'd5, 1'b0);
        step(1'b1, 16'd150, 1'b0);
        step(1'b1, 16'd5, 1'b0); step(1'b1, 16'd5, 1'b0);
        expect_flag("R5", 1'b0);
        step(1'b1, 16'd5, 1'b0); expect_flag("R5", 1'b1);
        clear_all();

        // R9: gaps without a strobe do not advance or reset the run.
        code = 4'd2;
        step(1'b1, 16'd5, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 16'd5, 1'b0);
        expect_flag("R9", 1'b0);
        step(1'b1, 16'd5, 1'b0); expect_flag("R9", 1'b1);
        clear_all();

        // R6: clear restarts the count.
        step(1'b1, 16'd5, 1'b0);
        clear_all();
        step(1'b1, 16'd5, 1'b0); expect_flag("R6", 1'b0);
        step(1'b1, 16'd5, 1'b0); expect_flag("R6", 1'b1);
        clear_all();

        // R7: clear and qualifying sample together leave the flag set.
        code = 4'd1;
        step(1'b1, 16'd5, 1'b1); expect_flag("R7", 1'b1);
        clear_all();

        // R8: mask gates only the pin.
        en = 1'b0;
        step(1'b1, 16'd5, 1'b0); expect_flag("R8", 1'b1);
        en = 1'b1;
        #1; chk("R8", "irq_n", irq_n, 1'b0);
        clear_all(); expect_flag("R8", 1'b0);

        // Random traffic vs reference model (R1-R9).
        for (int i = 0; i < RAND_CYC; i++) begin
            if (i % 250 == 0) begin
                lo   = 16'($urandom % 512);
                hi   = 16'($urandom % 512);
                code = 4'($urandom % 8);
            end
            en = 1'($urandom % 2);
            step(1'($urandom % 2), 16'($urandom % 512), ($urandom % 16) == 0);
            chk("R4 random", "irq_flag", irq_flag, ref_flag);
            chk("R8 random", "irq_n", irq_n, !(ref_flag && en));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule